// File: doc/BRIEF.md
# Cluster Cache Flush Dispatcher

This block sits at cluster level and turns a software write into a flush or invalidate operation for the cache controllers of several tiles. Software first writes a tile-select mask, then writes a 2-bit operation code to the command register. The block works out the effective set of tiles, raises a one-cycle valid pulse with the operation code to all of those tiles in the same cycle, and sets one lock bit per targeted tile. Each tile answers with a one-cycle ready pulse when its own flush is done. That pulse clears the tile's lock bit.

While any lock bit is set, the `busy` output is high. This output gates core and remote-tile cache accesses. A new command written while busy is dropped and a sticky rejected flag is raised. Software polls the status register until the busy bit and the lock field read zero.

The sequencer has two states. In `ST_IDLE`, a command with a non-empty effective mask takes the ISSUE transition to `ST_WAIT`. In `ST_WAIT`, the DRAIN transition back to `ST_IDLE` happens in the cycle where the last outstanding lock bit is cleared. A command with an empty effective mask stays in `ST_IDLE`.

Top module: `flush_dispatch`

## Requirements
- R1: After reset `busy` is 0, `tile_valid` is 0, and the status register (address 2) reads 0, with busy in bit 0, rejected in bit 1 and the lock field in bits [8 +: NUM_TILES]. The mask register (address 1) also reads 0.
- R2: A command write (address 0, operation in bits [1:0]) with code 0 (private flush) issues to exactly the tiles set in the mask register (address 1, bits [NUM_TILES-1:0]). The valid mask appears in the cycle after the write, and `tile_insn` carries 0.
- R3: Codes 1 (shared flush), 2 (flush all) and 3 (invalidate) ignore the mask register and issue to all tiles. `tile_insn` carries the code.
- R4: `tile_valid` is high for exactly one cycle per accepted command, on all targeted tiles together.
- R5: Each targeted tile's lock bit is set on issue and cleared by that tile's ready pulse. `busy` rises in the cycle after the command write and stays high while any lock bit is set.
- R6: A command write while `busy` is high is dropped: no valid pulse and no change to the lock field. The rejected flag (status bit 1) is set and stays set until software writes status with bit 1 = 1.
- R7: A private flush with an all-zero mask produces no valid pulse, does not raise `busy` and does not set rejected.
- R8: A ready pulse from a tile whose lock bit is clear has no effect on the lock field or on `busy`.
- R9: `busy` falls in the cycle after the last lock bit is cleared, and a command written in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 command, 1 mask, 2 status) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| tile_valid | output | NUM_TILES | One-cycle issue pulse per tile |
| tile_insn | output | 2 | Operation code broadcast to tiles |
| tile_ready | input | NUM_TILES | One-cycle completion pulse per tile |
| busy | output | 1 | High while any flush is in flight |

## Verification
Private flushes are issued with sparse, single-tile and empty masks. This shows that the mask register is honoured for code 0 and that an empty selection never enters `ST_WAIT`. The other three codes are issued with a deliberately partial mask, so any leak of the software mask into the forced all-ones set is visible.

Ready pulses are sent from unlocked tiles, from a subset of locked tiles, and from the last locked tile. These cases separate ignoring a stray pulse, partial drain, and the DRAIN transition. A command written while busy, and another written in the first idle cycle, tell rejection apart from back-to-back acceptance.

// File: rtl/flush_pkg.sv
package flush_pkg;

    typedef enum logic [1:0] {
        OP_PRIVATE = 2'd0,
        OP_SHARED  = 2'd1,
        OP_ALL     = 2'd2,
        OP_INVAL   = 2'd3
    } flush_op_e;

    localparam int REG_CMD    = 0;
    localparam int REG_MASK   = 1;
    localparam int REG_STATUS = 2;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_REJ_BIT  = 1;
    localparam int STAT_LOCK_LSB = 8;

endpackage

// File: rtl/flush_regs.sv
module flush_regs
    import flush_pkg::*;
#(
    parameter int NUM_TILES = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 cmd_drop,
    input  logic                 busy,
    input  logic [NUM_TILES-1:0] lock,
    input  logic [1:0]           last_op,
    output logic                 cmd_req,
    output logic [1:0]           cmd_op,
    output logic [NUM_TILES-1:0] sw_mask
);

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(REG_CMD);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STATUS);

    logic                 rej_q;
    logic [NUM_TILES-1:0] mask_q;
    logic                 unused_wr;

    assign unused_wr = ^wr_data;

    assign cmd_req = wr_en && (wr_addr == A_CMD);
    assign cmd_op  = wr_data[1:0];
    assign sw_mask = mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            rej_q  <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == A_MASK))
                mask_q <= wr_data[NUM_TILES-1:0];
            if (wr_en && (wr_addr == A_STAT) && wr_data[STAT_REJ_BIT])
                rej_q <= 1'b0;
            else if (cmd_drop)
                rej_q <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CMD) begin
            rd_data[1:0] = last_op;
        end else if (rd_addr == A_MASK) begin
            rd_data[NUM_TILES-1:0] = mask_q;
        end else if (rd_addr == A_STAT) begin
            rd_data[STAT_BUSY_BIT]                = busy;
            rd_data[STAT_REJ_BIT]                 = rej_q;
            rd_data[STAT_LOCK_LSB +: NUM_TILES]   = lock;
        end
    end

endmodule

// File: rtl/flush_seq.sv
module flush_seq
    import flush_pkg::*;
#(
    parameter int NUM_TILES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_req,
    input  logic [1:0]           cmd_op,
    input  logic [NUM_TILES-1:0] sw_mask,
    input  logic [NUM_TILES-1:0] tile_ready,
    output logic [NUM_TILES-1:0] tile_valid,
    output logic [1:0]           tile_insn,
    output logic [NUM_TILES-1:0] lock_q,
    output logic                 busy,
    output logic                 cmd_drop
);

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_state_e;

    seq_state_e           state_q, state_d;
    logic [NUM_TILES-1:0] eff_mask;
    logic [NUM_TILES-1:0] lock_left;
    logic                 do_issue;

    assign eff_mask  = (flush_op_e'(cmd_op) == OP_PRIVATE) ? sw_mask : '1;
    assign lock_left = lock_q & ~tile_ready;
    assign do_issue  = (state_q == ST_IDLE) && cmd_req;
    assign busy      = (state_q == ST_WAIT);
    assign cmd_drop  = (state_q == ST_WAIT) && cmd_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_req && (eff_mask != '0)) state_d = ST_WAIT;
            ST_WAIT: if (lock_left == '0)             state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tile_valid <= '0;
            tile_insn  <= 2'd0;
            lock_q     <= '0;
        end else begin
            tile_valid <= do_issue ? eff_mask : '0;
            if (do_issue) begin
                tile_insn <= cmd_op;
                lock_q    <= eff_mask;
            end else begin
                lock_q    <= lock_left;
            end
        end
    end

endmodule

// File: rtl/flush_dispatch.sv
module flush_dispatch
    import flush_pkg::*;
#(
    parameter int NUM_TILES = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_TILES-1:0] tile_valid,
    output logic [1:0]           tile_insn,
    input  logic [NUM_TILES-1:0] tile_ready,
    output logic                 busy
);

    logic                 cmd_req;
    logic                 cmd_drop;
    logic [1:0]           cmd_op;
    logic [NUM_TILES-1:0] sw_mask;
    logic [NUM_TILES-1:0] lock_w;

    flush_regs #(
        .NUM_TILES(NUM_TILES),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cmd_drop(cmd_drop),
        .busy    (busy),
        .lock    (lock_w),
        .last_op (tile_insn),
        .cmd_req (cmd_req),
        .cmd_op  (cmd_op),
        .sw_mask (sw_mask)
    );

    flush_seq #(
        .NUM_TILES(NUM_TILES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_req   (cmd_req),
        .cmd_op    (cmd_op),
        .sw_mask   (sw_mask),
        .tile_ready(tile_ready),
        .tile_valid(tile_valid),
        .tile_insn (tile_insn),
        .lock_q    (lock_w),
        .busy      (busy),
        .cmd_drop  (cmd_drop)
    );

endmodule

// File: rtl/flush_dispatch_chk.sv
module flush_dispatch_chk #(
    parameter int NUM_TILES = 4,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [1:0]           wr_op,
    input logic [NUM_TILES-1:0] tile_valid,
    input logic [NUM_TILES-1:0] tile_ready,
    input logic [NUM_TILES-1:0] lock_q,
    input logic                 busy
);

    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_addr == '0);

    // R3: non-private op accepted while idle goes to every tile
    assert_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && (wr_op != 2'd0)) |=> (tile_valid == '1));

    // R4: the valid pulse lasts exactly one cycle
    assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_valid != '0) |=> (tile_valid == '0));

    // R5: busy tracks the lock field
    assert_busy_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (lock_q != '0));

    // R5: a lock bit only falls on a ready pulse from that tile
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((($past(lock_q) & ~lock_q) & ~$past(tile_ready)) == '0));

    // R6: a command while busy produces no pulse
    assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> (tile_valid == '0));

    // R8: no lock bit rises without a command write
    assert_norise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> ((lock_q & ~$past(lock_q)) == '0));

endmodule

bind flush_dispatch flush_dispatch_chk #(
    .NUM_TILES(NUM_TILES),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_op     (wr_data[1:0]),
    .tile_valid(tile_valid),
    .tile_ready(tile_ready),
    .lock_q    (lock_w),
    .busy      (busy)
);

// File: tb/flush_dispatch_test.sv
`timescale 1ns/1ps
module flush_dispatch_test;

    localparam int NT = 4;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NT-1:0] tile_valid;
    logic [1:0]    tile_insn;
    logic [NT-1:0] tile_ready = '0;
    logic          busy;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [NT+1:0] exp_q[$];
    int            tag_q[$];

    always #4 clk = ~clk;

    flush_dispatch #(.NUM_TILES(NT), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tile_valid(tile_valid), .tile_insn(tile_insn),
        .tile_ready(tile_ready), .busy(busy)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reg_read(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_addr = AW'(a);
        #1 d = rd_data;
    endtask

    // Driver: push the expected issue, then write the command
    task automatic issue(input logic [1:0] op, input logic [NT-1:0] exp_mask, input int tag);
        exp_q.push_back({op, exp_mask});
        tag_q.push_back(tag);
        reg_write(0, DW'(op));
    endtask

    task automatic pulse_ready(input logic [NT-1:0] m);
        @(negedge clk);
        tile_ready = m;
        @(negedge clk);
        tile_ready = '0;
    endtask

    function automatic logic [DW-1:0] stat(input logic b, input logic r, input logic [NT-1:0] l);
        logic [DW-1:0] s;
        s = '0; s[0] = b; s[1] = r; s[8 +: NT] = l;
        return s;
    endfunction

    // Monitor: every valid pulse must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && (tile_valid != '0)) begin
            if (exp_q.size() == 0) begin
                vectors++; miscompares++;
                $display("FAIL R6 actual=%h expected=%h (unexpected pulse)", tile_valid, {NT{1'b0}});
            end else begin
                logic [NT+1:0] e;
                int t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if ({tile_insn, tile_valid} !== e) begin
                    miscompares++;
                    $display("FAIL R%0d actual=%h expected=%h", t, {tile_insn, tile_valid}, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2, d); check("R1 status", d, '0);
        reg_read(1, d); check("R1 mask", d, '0);
        check("R1 busy", DW'(busy), '0);
        check("R1 valid", DW'(tile_valid), '0);

        // R2 private flush with sparse mask
        reg_write(1, DW'(4'b0101));
        issue(2'd0, 4'b0101, 2);
        check("R5 busy rises", DW'(busy), 1);
        @(negedge clk);
        check("R4 valid single cycle", DW'(tile_valid), '0);
        reg_read(2, d); check("R5 lock set", d, stat(1, 0, 4'b0101));

        // R8 stray ready from unlocked tile 1
        pulse_ready(4'b0010);
        reg_read(2, d); check("R8 stray ready", d, stat(1, 0, 4'b0101));
        // R5 partial drain
        pulse_ready(4'b0001);
        reg_read(2, d); check("R5 partial drain", d, stat(1, 0, 4'b0100));

        // R6 command while busy is dropped
        reg_write(0, DW'(2'd2));
        reg_read(2, d); check("R6 rejected", d, stat(1, 1, 4'b0100));

        // R9 last ready, then command accepted in first idle cycle
        @(negedge clk); tile_ready = 4'b0100;
        @(negedge clk); tile_ready = '0;
        check("R9 busy falls", DW'(busy), 0);
        exp_q.push_back({2'd1, 4'b1111}); tag_q.push_back(9);
        wr_en = 1'b1; wr_addr = '0; wr_data = DW'(2'd1);
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        check("R9 accepted", DW'(busy), 1);
        reg_read(2, d); check("R6 sticky", d, stat(1, 1, 4'b1111));
        pulse_ready(4'b1111);
        reg_read(2, d); check("R5 drained", d, stat(0, 1, 4'b0000));
        reg_write(2, DW'(2'b10));
        reg_read(2, d); check("R6 clear", d, '0);

        // R3 forced all-ones for codes 2 and 3 with partial mask
        issue(2'd2, 4'b1111, 3);
        pulse_ready(4'b1111);
        issue(2'd3, 4'b1111, 3);
        pulse_ready(4'b0011);
        reg_read(2, d); check("R3 inval lock", d, stat(1, 0, 4'b1100));
        pulse_ready(4'b1100);
        reg_read(0, d); check("R3 last op", d, DW'(2'd3));

        // R2 single tile
        reg_write(1, DW'(4'b1000));
        issue(2'd0, 4'b1000, 2);
        reg_read(2, d); check("R2 single lock", d, stat(1, 0, 4'b1000));
        pulse_ready(4'b1000);

        // R7 private flush with empty mask
        reg_write(1, '0);
        reg_write(0, DW'(2'd0));
        check("R7 no busy", DW'(busy), 0);
        reg_read(2, d); check("R7 status", d, '0);

        repeat (3) @(negedge clk);
        check("R4 queue empty", DW'(exp_q.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule